// File: doc/BRIEF.md
# Reloading Down-Count Interval Timer Pair

This block holds two independent 32-bit interval timers behind one simple register port. Each timer has a terminal-count register, a control register, a read-only live-count register and a status register. Once enabled, a timer takes its terminal value and counts down by one on every clock. When it reaches zero it sets a sticky expiry flag. It can then either reload and keep running, or park at zero until software acknowledges the flag. Each timer has its own interrupt line, which shows the expiry flag only when its interrupt enable is set.

Reads use a single-cycle strobe. The addressed value is captured into a holding register, and the read-data port drives that register until the next strobe. A slow bus can therefore take several cycles to sample the count while the live counter keeps moving.

Top module: `dual_slice_timer`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low.
- R2: Timer i (i = 0, 1) uses the byte addresses 0x900 + 0x10*i (terminal count), +0x4 (control), +0x8 (live count) and +0xC (status). Any other address reads 0 and writes to it are ignored.
- R3: Control register fields: bit 24 enables the timer, bit 25 enables the interrupt, and bit 26 selects continuous (1) or wait (0) mode. All other control bits read 0 and ignore writes.
- R4: On the first clock after the enable bit is written from 0 to 1, the count takes the terminal value. It then drops by exactly one on each following clock.
- R5: While the enable bit is 0, the count becomes 0 on the next clock and stays there.
- R6: On the clock where the count steps from 1 to 0 (the expiry), status bit 25 is set and stays set. Writing 1 to status bit 25 clears it. Writing 0 to it has no effect.
- R7: In continuous mode, the count takes the terminal value at the expiry clock instead of 0, so it runs with a period equal to the terminal value.
- R8: In wait mode, the count stays at 0 after expiry while the status bit is set. It takes the terminal value again on the clock after the status bit is cleared, or on the clock after the enable bit rises again following a disable.
- R9: Interrupt line i is high exactly while timer i's status bit and interrupt enable are both 1. The interrupt enable never changes counting or the status bit.
- R10: A read strobe captures the addressed register as it stands in the strobe cycle. The read-data port shows that value from the next clock on and keeps it unchanged until the next strobe, while the counter keeps running.
- R11: The two timers are fully independent: registers, counting, status and interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read-data holding register |
| irq | output | 2 | Interrupt line per timer |

## Verification
The bench builds the block with its default parameters: a 32-bit count, two timers, the first live-count register at 0x908, and a stride of 0x10. Because software chooses the terminal value, small values of 3, 4 and 10 bring expiry, continuous reload, the wait-mode stall and its two release paths within a few dozen cycles. With both timers instantiated, the bench can check that one timer's expiry and acknowledge leave the other timer untouched.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int DATA_W  = 32;
  localparam int EN_BIT  = 24;
  localparam int IEN_BIT = 25;
  localparam int RUN_BIT = 26;
  localparam int EXP_BIT = 25;

  typedef enum logic [1:0] {
    REG_TERM  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_COUNT = 2'd2,
    REG_STAT  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic run;
    logic ien;
    logic en;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
    ctrl_t c;
    c.run = d[RUN_BIT];
    c.ien = d[IEN_BIT];
    c.en  = d[EN_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    logic [DATA_W-1:0] d;
    d = '0;
    d[RUN_BIT] = c.run;
    d[IEN_BIT] = c.ien;
    d[EN_BIT]  = c.en;
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] pack_stat(input logic s);
    logic [DATA_W-1:0] d;
    d = '0;
    d[EXP_BIT] = s;
    return d;
  endfunction
endpackage

// File: rtl/dst_decode.sv
module dst_decode
  import dst_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int N_TIMERS    = 2,
  parameter int CNT_BASE    = 'h908,
  parameter int INST_STRIDE = 'h10,
  localparam int IDX_W      = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  output logic [N_TIMERS-1:0] wr_term,
  output logic [N_TIMERS-1:0] wr_ctrl,
  output logic [N_TIMERS-1:0] wr_stat,
  output logic                hit,
  output logic [IDX_W-1:0]    inst,
  output reg_kind_e           kind
);
  localparam int FIRST = CNT_BASE - 8;

  logic [N_TIMERS-1:0]             hit_v;
  logic [N_TIMERS-1:0][ADDR_W-1:0] off_v;

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_win
    assign off_v[i] = addr - ADDR_W'(FIRST + i * INST_STRIDE);
    assign hit_v[i] = (off_v[i][ADDR_W-1:4] == '0) && (off_v[i][1:0] == 2'b00);
    assign wr_term[i] = wr && hit_v[i] && (reg_kind_e'(off_v[i][3:2]) == REG_TERM);
    assign wr_ctrl[i] = wr && hit_v[i] && (reg_kind_e'(off_v[i][3:2]) == REG_CTRL);
    assign wr_stat[i] = wr && hit_v[i] && (reg_kind_e'(off_v[i][3:2]) == REG_STAT);
  end

  always_comb begin
    hit  = 1'b0;
    inst = '0;
    kind = REG_TERM;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (hit_v[i]) begin
        hit  = 1'b1;
        inst = IDX_W'(i);
        kind = reg_kind_e'(off_v[i][3:2]);
      end
    end
  end
endmodule

// File: rtl/dst_channel.sv
module dst_channel
  import dst_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_term,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic [CNT_W-1:0] term_wdata,
  input  ctrl_t            ctrl_wdata,
  input  logic             clr_req,
  output logic [CNT_W-1:0] term,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] cnt,
  output logic             status,
  output logic             irq,
  output logic             arm_evt,
  output logic             expire_evt
);
  logic en_q;
  logic tick;

  // count for the next clock, given the present state
  function automatic logic [CNT_W-1:0] next_count(
    input ctrl_t            c,
    input logic             armed,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] tval,
    input logic             sticky
  );
    if (!c.en)                   return '0;
    if (armed)                   return tval;
    if (cur == CNT_W'(1))        return c.run ? tval : '0;
    if (cur == '0)               return (c.run || !sticky) ? tval : '0;
    return cur - CNT_W'(1);
  endfunction

  assign arm_evt    = ctrl.en && !en_q;
  assign tick       = ctrl.en && en_q;
  assign expire_evt = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term   <= '0;
      ctrl   <= '0;
      en_q   <= 1'b0;
      cnt    <= '0;
      status <= 1'b0;
    end else begin
      if (wr_term) term <= term_wdata;
      if (wr_ctrl) ctrl <= ctrl_wdata;
      en_q <= ctrl.en;
      cnt  <= next_count(ctrl, arm_evt, cnt, term, status);
      if (expire_evt)              status <= 1'b1;
      else if (wr_stat && clr_req) status <= 1'b0;
    end
  end

  assign irq = status && ctrl.ien;
endmodule

// File: rtl/dst_rdhold.sv
module dst_rdhold
  import dst_pkg::*;
#(
  parameter int N_TIMERS = 2,
  localparam int IDX_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd,
  input  logic                            hit,
  input  logic [IDX_W-1:0]                inst,
  input  reg_kind_e                       kind,
  input  logic [N_TIMERS-1:0][DATA_W-1:0] term_w,
  input  logic [N_TIMERS-1:0][DATA_W-1:0] ctrl_w,
  input  logic [N_TIMERS-1:0][DATA_W-1:0] cnt_w,
  input  logic [N_TIMERS-1:0][DATA_W-1:0] stat_w,
  output logic [DATA_W-1:0]               rdata
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    if (hit) begin
      unique case (kind)
        REG_TERM:  pick = term_w[inst];
        REG_CTRL:  pick = ctrl_w[inst];
        REG_COUNT: pick = cnt_w[inst];
        REG_STAT:  pick = stat_w[inst];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= pick;
  end
endmodule

// File: rtl/dual_slice_timer.sv
module dual_slice_timer
  import dst_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int N_TIMERS    = 2,
  parameter int CNT_W       = 32,
  parameter int CNT_BASE    = 'h908,
  parameter int INST_STRIDE = 'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [N_TIMERS-1:0] irq
);
  localparam int IDX_W = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;

  logic [N_TIMERS-1:0]             wr_term, wr_ctrl, wr_stat;
  logic                            rd_hit;
  logic [IDX_W-1:0]                rd_inst;
  reg_kind_e                       rd_kind;

  // named internal events, observed by the bound checker
  logic [N_TIMERS-1:0]             arm_evt, expire_evt;
  logic [N_TIMERS-1:0]             en_v, run_v, ien_v, stat_v;
  logic [N_TIMERS-1:0][CNT_W-1:0]  cnt_a, term_a;
  logic [N_TIMERS-1:0][DATA_W-1:0] term_w, ctrl_w, cnt_w, stat_w;

  dst_decode #(
    .ADDR_W(ADDR_W), .N_TIMERS(N_TIMERS),
    .CNT_BASE(CNT_BASE), .INST_STRIDE(INST_STRIDE)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr),
    .wr_term(wr_term), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .hit(rd_hit), .inst(rd_inst), .kind(rd_kind)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    ctrl_t ctrl_i;

    dst_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_term(wr_term[i]), .wr_ctrl(wr_ctrl[i]), .wr_stat(wr_stat[i]),
      .term_wdata(bus_wdata[CNT_W-1:0]),
      .ctrl_wdata(unpack_ctrl(bus_wdata)),
      .clr_req(bus_wdata[EXP_BIT]),
      .term(term_a[i]), .ctrl(ctrl_i), .cnt(cnt_a[i]),
      .status(stat_v[i]), .irq(irq[i]),
      .arm_evt(arm_evt[i]), .expire_evt(expire_evt[i])
    );

    assign en_v[i]   = ctrl_i.en;
    assign run_v[i]  = ctrl_i.run;
    assign ien_v[i]  = ctrl_i.ien;
    assign term_w[i] = DATA_W'(term_a[i]);
    assign cnt_w[i]  = DATA_W'(cnt_a[i]);
    assign ctrl_w[i] = pack_ctrl(ctrl_i);
    assign stat_w[i] = pack_stat(stat_v[i]);
  end

  dst_rdhold #(.N_TIMERS(N_TIMERS)) u_rdhold (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd),
    .hit(rd_hit), .inst(rd_inst), .kind(rd_kind),
    .term_w(term_w), .ctrl_w(ctrl_w), .cnt_w(cnt_w), .stat_w(stat_w),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/dst_checker.sv
module dst_checker #(
  parameter int N_TIMERS = 2,
  parameter int CNT_W    = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_rd,
  input logic [31:0]                    bus_rdata,
  input logic [N_TIMERS-1:0]            irq,
  input logic [N_TIMERS-1:0]            en,
  input logic [N_TIMERS-1:0]            run,
  input logic [N_TIMERS-1:0]            ien,
  input logic [N_TIMERS-1:0]            status,
  input logic [N_TIMERS-1:0]            arm,
  input logic [N_TIMERS-1:0]            expire,
  input logic [N_TIMERS-1:0][CNT_W-1:0] cnt,
  input logic [N_TIMERS-1:0][CNT_W-1:0] term
);
  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    p_load_on_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arm[i] |=> cnt[i] == $past(term[i]));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && !arm[i] && cnt[i] > CNT_W'(1)) |=> cnt[i] == $past(cnt[i]) - CNT_W'(1));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> cnt[i] == '0);

    p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> status[i]);

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && run[i]) |=> cnt[i] == $past(term[i]));

    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en[i] && !arm[i] && !run[i] && status[i] && cnt[i] == '0) |=> cnt[i] == '0);

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && ien[i]) |=> (irq[i] || !ien[i]));
  end

  p_rdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind dual_slice_timer dst_checker #(.N_TIMERS(N_TIMERS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
  .en(en_v), .run(run_v), .ien(ien_v), .status(stat_v),
  .arm(arm_evt), .expire(expire_evt), .cnt(cnt_a), .term(term_a)
);

// File: tb/dual_slice_timer_tb_top.sv
`timescale 1ns/1ps
module dual_slice_timer_tb_top;
  localparam logic [11:0] TERM0 = 12'h900, CTRL0 = 12'h904, CNT0 = 12'h908, STAT0 = 12'h90C;
  localparam logic [11:0] TERM1 = 12'h910, CTRL1 = 12'h914, CNT1 = 12'h918, STAT1 = 12'h91C;
  localparam logic [31:0] C_EN = 32'h0100_0000, C_IEN = 32'h0200_0000, C_RUN = 32'h0400_0000;
  localparam logic [31:0] S_EXP = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit rd_seen  = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  dual_slice_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the falling edge after the sample
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: the read strobe seen at a rising edge is answered by that edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(bus_rdata, 32'hxxxx_xxxx, "R10 unexpected read");
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check({30'd0, irq}, 32'd0, "R1 irq after reset");
    rd_exp(TERM0, 0, "R1 term0"); rd_exp(CTRL0, 0, "R1 ctrl0");
    rd_exp(CNT0, 0, "R1 cnt0");   rd_exp(STAT0, 0, "R1 stat0");
    rd_exp(TERM1, 0, "R1 term1"); rd_exp(CTRL1, 0, "R1 ctrl1");
    rd_exp(CNT1, 0, "R1 cnt1");   rd_exp(STAT1, 0, "R1 stat1");
    // R2 map and unmapped address
    wr_reg(12'h920, 32'hDEAD_BEEF);
    rd_exp(12'h920, 0, "R2 unmapped");
    wr_reg(TERM0, 32'd10);
    rd_exp(TERM0, 32'd10, "R2 term0 readback");
    rd_exp(TERM1, 0, "R11 term1 untouched");
    // R3 reserved control bits
    wr_reg(CTRL0, 32'hF8FF_FFFF);
    rd_exp(CTRL0, 0, "R3 reserved bits");
    rd_exp(CNT0, 0, "R5 idle count");

    // R4 wait mode with interrupt: write sampled at edge E
    wr_reg(CTRL0, C_EN | C_IEN);
    idle(2);
    rd_exp(CNT0, 32'd9, "R4 count after load");
    idle(3);
    check(bus_rdata, 32'd9, "R10 held read data");
    rd_exp(CNT0, 32'd5, "R4 count steps");
    idle(3);
    check({30'd0, irq}, 32'd0, "R9 irq before expiry");
    idle(1);
    check({30'd0, irq}, 32'd1, "R6 irq at expiry");
    rd_exp(STAT0, S_EXP, "R6 status set");
    idle(4);
    rd_exp(CNT0, 0, "R8 wait hold");
    rd_exp(CTRL0, C_EN | C_IEN, "R3 ctrl readback");
    // R6 write of zero ignored, then W1C releases the wait
    wr_reg(STAT0, 32'h0);
    rd_exp(STAT0, S_EXP, "R6 zero write ignored");
    wr_reg(STAT0, S_EXP);
    check({30'd0, irq}, 32'd0, "R9 irq cleared");
    idle(1);
    rd_exp(CNT0, 32'd10, "R8 resume after clear");

    // R9 interrupt enable off: counting and status unaffected
    wr_reg(CTRL0, C_EN);
    idle(12);
    check({30'd0, irq}, 32'd0, "R9 masked irq");
    rd_exp(STAT0, S_EXP, "R9 status without ien");
    rd_exp(CNT0, 0, "R9 held without ien");
    wr_reg(CTRL0, C_EN | C_IEN);
    check({30'd0, irq}, 32'd1, "R9 irq on enable");

    // R8 disable then re-enable with status still set
    wr_reg(CTRL0, 32'h0);
    wr_reg(CTRL0, C_EN);
    idle(1);
    rd_exp(CNT0, 32'd10, "R8 resume after toggle");
    wr_reg(CTRL0, 32'h0);
    rd_exp(CNT0, 32'd8, "R5 last count before idle");
    rd_exp(CNT0, 0, "R5 forced zero");

    // R7 continuous mode, terminal 4
    wr_reg(STAT0, S_EXP);
    wr_reg(TERM0, 32'd4);
    wr_reg(CTRL0, C_EN | C_RUN);
    idle(4);
    rd_exp(CNT0, 32'd1, "R7 before expiry");
    rd_exp(CNT0, 32'd4, "R7 reload");
    rd_exp(CNT0, 32'd3, "R7 keeps running");
    rd_exp(STAT0, S_EXP, "R7 status in continuous");
    check({30'd0, irq}, 32'd0, "R9 no irq without ien");
    rd_exp(CNT0, 32'd1, "R7 second period");
    rd_exp(CNT0, 32'd4, "R7 second reload");
    wr_reg(CTRL0, 32'h0);
    wr_reg(STAT0, S_EXP);

    // R11 second timer alone
    wr_reg(TERM1, 32'd3);
    wr_reg(CTRL1, C_EN | C_IEN);
    rd_exp(CNT0, 0, "R11 timer0 idle");
    idle(3);
    check({30'd0, irq}, 32'd2, "R11 only irq1");
    rd_exp(STAT1, S_EXP, "R11 status1 set");
    rd_exp(STAT0, 0, "R11 status0 clear");
    wr_reg(STAT1, S_EXP);
    check({30'd0, irq}, 32'd0, "R11 irq1 cleared");

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule